// File: doc/BRIEF.md
# Residue-Domain Binary Field Multiplier

This block multiplies two elements of the binary extension field GF(2^163) when both operands and the product are held in polynomial residue form. Each operand arrives as four 84-bit residues, one for each channel modulus. Every modulus is an irreducible trinomial x^84 + x^k + 1. The block returns the four residues of the reduced field product and pulses a completion flag.

Inside, each channel first multiplies its two residues with a bit-serial, MSB-first multiplier. A second bit-serial multiplier then scales that channel product by a fixed inverse constant, which is shifted in one bit per cycle. The four scaled terms are placed at the offsets of the fixed cofactor polynomials by XOR routing. Only the part of the integer-free Chinese-remainder sum that lands at or above bit 163 is rebuilt. That high part is folded by the field polynomial, joined to the folded remainder and converted back to residues. The converted residues are then XORed with the registered channel products, which gives the residues of the reduced product.

The inverse constants and the cofactor polynomials are derived from the channel parameters when the design is elaborated.

Top module: `prns_crt_mul`

## Requirements
- R1: Lane i of `a_res`, `b_res` and `p_res` occupies bits [84*i+83 : 84*i] and holds a residue modulo x^84 + x^k_i + 1, with k = 5, 9, 11, 13 for lanes 0 to 3.
- R2: When `a_res` and `b_res` carry the residues of field elements A and B of degree below 163, each lane of `p_res` equals ((A·B) mod (x^163 + x^7 + x^6 + x^3 + 1)) mod the lane's trinomial.
- R3: The operands are captured on the clock edge that accepts `start`. Changing `a_res` or `b_res` after that edge has no effect on the result.
- R4: A `start` that is high while an operation is in progress is ignored. The running operation finishes with its original result and timing.
- R5: `done` rises 170 clock edges after the edge that accepts `start` (2·84 + 2), and `p_res` is valid in that same cycle.
- R6: `done` is high for exactly one cycle per operation.
- R7: `p_res` keeps its value in every cycle except the one in which `done` is high.
- R8: While reset is asserted, `done` is low and `p_res` is zero.
- R9: A `start` presented during the `done` cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| a_res | input | 336 | First operand, four packed residues |
| b_res | input | 336 | Second operand, four packed residues |
| p_res | output | 336 | Product, four packed residues |
| done | output | 1 | One-cycle pulse when `p_res` is valid |

## Verification
The product residues and `done` are due 170 edges after the edge that accepts `start`. For each operation the bench counts falling edges from the one on which it dropped `start`, and it requires `done` on the 171st. The bench compares `p_res` on that same falling edge against residues it computes itself from a reference field multiplication. It then checks that `done` is low one falling edge later and that `p_res` is unchanged three cycles after that. Operands are scrambled right after acceptance, a spurious `start` is injected mid-run, and one operation is launched in the `done` cycle of the one before it, so that the capture, ignore and chaining rules are each exercised.

// File: rtl/prns_pkg.sv
`timescale 1ns/1ps
package prns_pkg;
  localparam int FIELD_W = 163;
  localparam int CH_D    = 84;
  localparam int CH_N    = 4;
  // field polynomial x^163 + x^7 + x^6 + x^3 + 1
  localparam logic [FIELD_W:0] FIELD_POLY = {1'b1, 155'b0, 8'b1100_1001};
  // middle exponent of each channel trinomial, lane 0 in the low byte
  localparam logic [CH_N*8-1:0] CH_MID_DEF = 32'h0D0B_0905;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MUL  = 3'd1,
    S_LOAD = 3'd2,
    S_SCL  = 3'd3,
    S_FIN  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/prns_serial_mul.sv
`timescale 1ns/1ps
// MSB-first bit-serial multiplier modulo x^D + x^K + 1
module prns_serial_mul #(
  parameter int D = 84,
  parameter int K = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         first,
  input  logic         ser_bit,
  input  logic [D-1:0] par_in,
  output logic [D-1:0] acc
);
  localparam logic [D-1:0] ONE  = {{(D-1){1'b0}}, 1'b1};
  localparam logic [D-1:0] TAPS = (ONE << K) | ONE;

  logic [D-1:0] acc_q, acc_d, base, dbl;

  always_comb begin
    base  = first ? '0 : acc_q;
    dbl   = {base[D-2:0], 1'b0} ^ (base[D-1] ? TAPS : '0);
    acc_d = step ? (dbl ^ (ser_bit ? par_in : '0)) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/prns_field_fold.sv
`timescale 1ns/1ps
// Reduces hi * x^M_W modulo the field polynomial
module prns_field_fold #(
  parameter int             M_W    = 163,
  parameter int             W      = 336,
  parameter logic [M_W:0]   F_POLY = '1
) (
  input  logic [W-M_W-1:0] hi,
  output logic [M_W-1:0]   rem
);
  localparam logic [W-1:0] FEXT = {{(W-M_W-1){1'b0}}, F_POLY};

  logic [W-1:0] v;

  always_comb begin
    v = {hi, {M_W{1'b0}}};
    for (int b = W-1; b >= M_W; b--) begin
      if (v[b]) v = v ^ (FEXT << (b - M_W));
    end
    rem = v[M_W-1:0];
  end
endmodule

// File: rtl/prns_to_residue.sv
`timescale 1ns/1ps
// Converts a W-bit polynomial to N residues modulo x^D + x^k + 1
module prns_to_residue #(
  parameter int             N      = 4,
  parameter int             D      = 84,
  parameter int             W      = 336,
  parameter logic [N*8-1:0] CH_MID = '0
) (
  input  logic [W-1:0]   poly,
  output logic [N*D-1:0] res
);
  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam int             KG  = int'(CH_MID[g*8 +: 8]);
    localparam logic [W-1:0]   TRI = (ONE_W << D) | (ONE_W << KG) | ONE_W;
    logic [W-1:0] v;
    logic [D-1:0] lane_r;
    always_comb begin
      v = poly;
      for (int b = W-1; b >= D; b--) begin
        if (v[b]) v = v ^ (TRI << (b - D));
      end
      lane_r = v[D-1:0];
    end
    assign res[g*D +: D] = lane_r;
  end
endmodule

// File: rtl/prns_crt_mul.sv
`timescale 1ns/1ps
module prns_crt_mul
  import prns_pkg::*;
#(
  parameter int             M_W    = FIELD_W,
  parameter int             D      = CH_D,
  parameter int             N      = CH_N,
  parameter logic [M_W:0]   F_POLY = FIELD_POLY,
  parameter logic [N*8-1:0] CH_MID = CH_MID_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*D-1:0] a_res,
  input  logic [N*D-1:0] b_res,
  output logic [N*D-1:0] p_res,
  output logic           done
);
  localparam int W      = N*D;
  localparam int HI_W   = W - M_W;
  localparam int LO     = M_W - D + 1;   // lowest cofactor term reaching bit M_W
  localparam int MI_TOP = (N-1)*D;
  localparam int CW     = $clog2(D);
  localparam int LAT    = 2*D + 2;
  localparam logic [D:0] ONE_D1 = {{D{1'b0}}, 1'b1};
  localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

  // ---------------- elaboration-time constants ----------------
  function automatic logic [D:0] trin(int ch);
    logic [D:0] t;
    t = '0;
    t[D] = 1'b1;
    t[0] = 1'b1;
    t[int'(CH_MID[ch*8 +: 8])] = 1'b1;
    return t;
  endfunction

  function automatic int pdeg(logic [D:0] p);
    int r;
    r = 0;
    for (int i = 0; i <= D; i++) if (p[i]) r = i;
    return r;
  endfunction

  function automatic logic [W-1:0] cofactor(int ch);
    logic [W-1:0] prod, nxt;
    logic [D:0]   t;
    prod = ONE_W;
    for (int j = 0; j < N; j++) begin
      if (j != ch) begin
        t   = trin(j);
        nxt = '0;
        for (int b = 0; b <= D; b++) if (t[b]) nxt = nxt ^ (prod << b);
        prod = nxt;
      end
    end
    return prod;
  endfunction

  function automatic logic [D-1:0] mod_ch(logic [W-1:0] v_in, int ch);
    logic [W-1:0] v, t;
    v = v_in;
    t = {{(W-D-1){1'b0}}, trin(ch)};
    for (int b = W-1; b >= D; b--) if (v[b]) v = v ^ (t << (b - D));
    return v[D-1:0];
  endfunction

  function automatic logic [D-1:0] inv_ch(logic [D-1:0] a, int ch);
    logic [D:0] u, v, g1, g2, t;
    int j;
    u = {1'b0, a}; v = trin(ch); g1 = ONE_D1; g2 = '0;
    for (int it = 0; it < 4*D; it++) begin
      if (u != ONE_D1) begin
        j = pdeg(u) - pdeg(v);
        if (j < 0) begin
          t = u;  u = v;   v = t;
          t = g1; g1 = g2; g2 = t;
          j = -j;
        end
        u  = u ^ (v << j);
        g1 = g1 ^ (g2 << j);
      end
    end
    return g1[D-1:0];
  endfunction

  function automatic logic [N-1:0][W-1:0] all_cofactors();
    logic [N-1:0][W-1:0] r;
    for (int ch = 0; ch < N; ch++) r[ch] = cofactor(ch);
    return r;
  endfunction

  function automatic logic [W-1:0] all_inverses();
    logic [W-1:0] r;
    for (int ch = 0; ch < N; ch++) r[ch*D +: D] = inv_ch(mod_ch(cofactor(ch), ch), ch);
    return r;
  endfunction

  localparam logic [N-1:0][W-1:0] MIS    = all_cofactors();
  localparam logic [W-1:0]        ICONST = all_inverses();

  // ---------------- reset release ----------------
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  // ---------------- sequencer ----------------
  seq_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           accept, last_bit, done_d;

  assign accept   = (state_q == S_IDLE) && start;
  assign last_bit = (cnt_q == CW'(D-1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin state_d = S_MUL; cnt_d = '0; end
      S_MUL:  if (last_bit) state_d = S_LOAD; else cnt_d = cnt_q + 1'b1;
      S_LOAD: begin state_d = S_SCL; cnt_d = '0; end
      S_SCL:  if (last_bit) state_d = S_FIN; else cnt_d = cnt_q + 1'b1;
      S_FIN:  begin state_d = S_IDLE; done_d = 1'b1; end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done    <= done_d;
    end
  end

  // ---------------- operand and constant registers ----------------
  logic [W-1:0] a_q, bsr_q, isr_q, p_q, acc1, acc2, res_d;
  logic         en_mul, en_scl, en_fin, en_load;

  assign en_mul  = (state_q == S_MUL);
  assign en_load = (state_q == S_LOAD);
  assign en_scl  = (state_q == S_SCL);
  assign en_fin  = (state_q == S_FIN);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      a_q   <= '0;
      bsr_q <= '0;
      isr_q <= '0;
      p_q   <= '0;
      p_res <= '0;
    end else begin
      if (accept) a_q <= a_res;
      if (accept)      bsr_q <= b_res;
      else if (en_mul) for (int c = 0; c < N; c++) bsr_q[c*D +: D] <= {bsr_q[c*D +: D-1], 1'b0};
      if (en_load)     isr_q <= ICONST;
      else if (en_scl) for (int c = 0; c < N; c++) isr_q[c*D +: D] <= {isr_q[c*D +: D-1], 1'b0};
      if (en_load) p_q   <= acc1;   // first stage: channel products
      if (en_fin)  p_res <= res_d;  // second stage: reduced product
    end
  end

  // ---------------- per-channel serial multipliers ----------------
  for (genvar g = 0; g < N; g++) begin : g_ch
    localparam int KG = int'(CH_MID[g*8 +: 8]);
    prns_serial_mul #(.D(D), .K(KG)) i_mul_ab (
      .clk(clk), .rst_n(rst_s), .step(en_mul), .first(cnt_q == '0),
      .ser_bit(bsr_q[g*D + D-1]), .par_in(a_q[g*D +: D]), .acc(acc1[g*D +: D])
    );
    prns_serial_mul #(.D(D), .K(KG)) i_mul_inv (
      .clk(clk), .rst_n(rst_s), .step(en_scl), .first(cnt_q == '0),
      .ser_bit(isr_q[g*D + D-1]), .par_in(p_q[g*D +: D]), .acc(acc2[g*D +: D])
    );
  end

  // ---------------- partial reconstruction of the high bits ----------------
  logic [HI_W-1:0] hi_top;
  always_comb begin
    hi_top = '0;
    for (int ch = 0; ch < N; ch++) begin
      for (int j = LO; j <= MI_TOP; j++) begin
        if (MIS[ch][j])
          hi_top = hi_top ^ HI_W'((W'(acc2[ch*D +: D]) << j) >> M_W);
      end
    end
  end

  logic [M_W-1:0] fold_rem;
  logic [W-1:0]   conv_res;

  prns_field_fold #(.M_W(M_W), .W(W), .F_POLY(F_POLY)) i_fold (
    .hi(hi_top), .rem(fold_rem)
  );

  prns_to_residue #(.N(N), .D(D), .W(W), .CH_MID(CH_MID)) i_conv (
    .poly({hi_top, fold_rem}), .res(conv_res)
  );

  assign res_d = conv_res ^ p_q;

  // ---------------- assertions ----------------
  logic [15:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)              lat_cnt <= '0;
    else if (accept)         lat_cnt <= 16'd1;
    else if (done)           lat_cnt <= '0;
    else if (lat_cnt != '0)  lat_cnt <= lat_cnt + 16'd1;
  end

  p_done_latency_r5: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (lat_cnt == 16'(LAT + 1)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(p_res) |-> done);

  p_busy_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q != S_IDLE && start) |=> $stable(a_q));
endmodule

// File: tb/test_prns_crt_mul.sv
`timescale 1ns/1ps
module test_prns_crt_mul;
  localparam int FW  = 163;
  localparam int D   = 84;
  localparam int N   = 4;
  localparam int W   = N*D;
  localparam int LAT = 2*D + 2;
  localparam logic [FW:0] FPOLY = {1'b1, 155'b0, 8'b1100_1001};

  logic clk, rst_n, start, done;
  logic [W-1:0] a_res, b_res, p_res;
  int nchk, nfail;
  bit finished;

  prns_crt_mul i_prns_crt_mul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_res(a_res), .b_res(b_res), .p_res(p_res), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int mid_of(int ch);
    case (ch)
      0: return 5;
      1: return 9;
      2: return 11;
      default: return 13;
    endcase
  endfunction

  function automatic logic [FW-1:0] gf_mul(logic [FW-1:0] a, logic [FW-1:0] b);
    logic [2*FW-1:0] p, f;
    p = '0;
    for (int i = 0; i < FW; i++) if (b[i]) p = p ^ ({{FW{1'b0}}, a} << i);
    f = {{(FW-1){1'b0}}, FPOLY};
    for (int i = 2*FW-1; i >= FW; i--) if (p[i]) p = p ^ (f << (i - FW));
    return p[FW-1:0];
  endfunction

  function automatic logic [W-1:0] to_lanes(logic [FW-1:0] v);
    logic [W-1:0] r;
    logic [FW-1:0] t, m;
    for (int ch = 0; ch < N; ch++) begin
      t = v;
      m = '0; m[D] = 1'b1; m[mid_of(ch)] = 1'b1; m[0] = 1'b1;
      for (int i = FW-1; i >= D; i--) if (t[i]) t = t ^ (m << (i - D));
      r[ch*D +: D] = t[D-1:0];
    end
    return r;
  endfunction

  function automatic logic [FW-1:0] rnd_elem();
    logic [FW-1:0] r;
    for (int i = 0; i < 6; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_wide();
    logic [W-1:0] r;
    for (int i = 0; i < 11; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // chain: return at the done cycle so the next operation starts there (R9)
  // poke: raise start while busy with other operands (R4)
  task automatic run_op(input logic [FW-1:0] A, input logic [FW-1:0] B,
                        input bit poke, input bit chain, input string tag);
    logic [W-1:0] exp;
    int cnt;
    exp   = to_lanes(gf_mul(A, B));
    a_res = to_lanes(A);
    b_res = to_lanes(B);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_res = rnd_wide();   // R3: scramble after capture
    b_res = rnd_wide();
    cnt = 1;
    while (!done && cnt < 1000) begin
      if (poke && cnt == 20) begin
        start = 1'b1;
        a_res = rnd_wide();
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check({tag, " R5 latency"}, W'(cnt), W'(LAT + 1));
    check({tag, " R1 R2 R3 product residues"}, p_res, exp);
    if (!chain) begin
      @(negedge clk);
      check({tag, " R6 done single cycle"}, W'(done), W'(0));
      repeat (3) @(negedge clk);
      check({tag, " R7 result held"}, p_res, exp);
    end
  endtask

  initial begin
    logic [FW-1:0] ones, top;
    finished = 1'b0;
    nchk = 0; nfail = 0;
    void'($urandom(32'd9173));
    rst_n = 1'b0; start = 1'b0; a_res = '0; b_res = '0;
    repeat (3) @(negedge clk);
    check("R8 reset done", W'(done), W'(0));
    check("R8 reset result", p_res, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    ones = '1;
    top  = '0; top[FW-1] = 1'b1;
    run_op('0, rnd_elem(), 1'b0, 1'b0, "zero operand");
    run_op({{(FW-1){1'b0}}, 1'b1}, rnd_elem(), 1'b0, 1'b0, "unit operand");
    run_op(top, top, 1'b0, 1'b0, "top bits");
    run_op(ones, ones, 1'b0, 1'b0, "all ones");
    for (int k = 0; k < 8; k++) run_op(rnd_elem(), rnd_elem(), 1'b0, 1'b0, "random");
    run_op(rnd_elem(), rnd_elem(), 1'b1, 1'b0, "R4 busy start");
    run_op(rnd_elem(), rnd_elem(), 1'b0, 1'b1, "chain head");
    run_op(rnd_elem(), rnd_elem(), 1'b0, 1'b0, "R9 back to back");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule